// File: doc/BRIEF.md
# Low-Side Driver Overcurrent Sequencer

This block sequences the protection of a bank of low-side switches, four by default. Each channel has a request input that asks for the switch to be on, and a current-limit flag from an analog comparator. A limit flag that stays high for long enough trips that channel. A tripped channel is forced off and pulls down a shared active-low fault line. After a fixed retry interval, the channel clears itself and follows its request again.

A synchronous fault-clear input ends any trip at once. An over-temperature flag turns every switch off and lowers the fault line for as long as it stays high, and operation resumes when it falls. An undervoltage flag turns every switch off and holds all sequencing state cleared. Both time intervals are parameters counted in system-clock cycles.

Top module: `ocp_guard`

## Requirements
- R1: A channel trips on the clock edge where its limit flag has been sampled high on DEG_CYC consecutive edges. DEG_CYC is 350 by default, which is 3.5 us at 100 MHz.
- R2: A limit flag that is high on fewer than DEG_CYC consecutive edges does not trip the channel. Any edge that samples the flag low restarts the consecutive count from zero.
- R3: While a channel is tripped, its bit of `on_o` is 0 and `fault_n_o` is 0. Channels that are not tripped keep following their requests.
- R4: A trip lasts exactly RETRY_CYC clock edges and then clears by itself. The limit flag is ignored during the trip, and after the trip the consecutive count starts again from zero. RETRY_CYC is 120000 by default.
- R5: When `clr_i` is high at a clock edge, every trip and every partial deglitch count is cleared at that edge.
- R6: While `ot_i` is high, `on_o` is all zeros and `fault_n_o` is 0. When `ot_i` falls, both outputs go back to their normal values without any further action.
- R7: While `uv_i` is high, `on_o` is all zeros with no clock delay. Every clock edge with `uv_i` high clears all trips and partial counts.
- R8: Bit i of `on_o` equals `req_i[i]` AND channel i not tripped AND `ot_i` low AND `uv_i` low. `fault_n_o` is 0 exactly when any channel is tripped or `ot_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_i | input | NCH | Per-channel current-limit-active flag |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Undervoltage flag |
| clr_i | input | 1 | Synchronous fault clear, active high |
| req_i | input | NCH | Per-channel requested-on |
| on_o | output | NCH | Per-channel gated switch enable |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The hardest conditions to reach are at the boundaries of the two counts. These are a limit pulse one edge shorter than the deglitch window, the same pulse resumed after a single low edge, and the edge on which a trip expires while the limit flag is still high. The bench reaches these by holding the flag for exact edge counts with scaled-down parameters. It then checks the output one edge before and one edge after each boundary. It also places a clear or an undervoltage pulse in the middle of a partial count, then proves the count was dropped by showing that a further window one edge short does not trip the channel.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic {
    CH_RUN  = 1'b0,
    CH_TRIP = 1'b1
  } ch_state_e;

  function automatic int larger_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ocp_chan.sv
module ocp_chan
  import ocp_pkg::*;
#(
  parameter int DEG_CYC   = 350,
  parameter int RETRY_CYC = 120000,
  parameter int CW        = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lim_i,
  input  logic clr_i,
  input  logic uv_i,
  output logic fault_o
);

  localparam logic [CW-1:0] DEG_LAST   = CW'(DEG_CYC - 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

  ch_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr_i || uv_i) begin
      state_d = CH_RUN;
      cnt_d   = '0;
    end else begin
      case (state_q)
        CH_RUN: begin
          if (lim_i) begin
            if (cnt_q == DEG_LAST) begin
              state_d = CH_TRIP;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        CH_TRIP: begin
          if (cnt_q == RETRY_LAST) begin
            state_d = CH_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = CH_RUN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign upd_en = clr_i | uv_i | lim_i | (state_q == CH_TRIP) | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_RUN;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fault_o = (state_q == CH_TRIP);

  // R1
  trip_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(lim_i));

  // R2
  low_blocks_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_i && !fault_o) |=> !fault_o);

  // R5
  clear_drops_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !fault_o);

  // R7
  uv_drops_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> !fault_o);

endmodule

// File: rtl/ocp_gate.sv
module ocp_gate #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] trip_i,
  input  logic           ot_i,
  input  logic           uv_i,
  output logic [NCH-1:0] on_o,
  output logic           fault_n_o
);

  logic kill_all;

  assign kill_all  = ot_i | uv_i;
  assign on_o      = req_i & ~trip_i & {NCH{~kill_all}};
  assign fault_n_o = ~((|trip_i) | ot_i);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DEG_CYC   = 350,
  parameter int RETRY_CYC = 120000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lim_i,
  input  logic           ot_i,
  input  logic           uv_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] on_o,
  output logic           fault_n_o
);

  localparam int CW = $clog2(larger_of(DEG_CYC, RETRY_CYC) + 1);

  logic [NCH-1:0] trip;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ocp_chan #(
      .DEG_CYC  (DEG_CYC),
      .RETRY_CYC(RETRY_CYC),
      .CW       (CW)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .lim_i  (lim_i[g]),
      .clr_i  (clr_i),
      .uv_i   (uv_i),
      .fault_o(trip[g])
    );
  end

  ocp_gate #(
    .NCH(NCH)
  ) u_gate (
    .req_i    (req_i),
    .trip_i   (trip),
    .ot_i     (ot_i),
    .uv_i     (uv_i),
    .on_o     (on_o),
    .fault_n_o(fault_n_o)
  );

  // R3
  tripped_is_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_o & trip) == '0);

  // R3
  trip_lowers_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|trip) |-> !fault_n_o);

  // R6
  hot_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |-> (on_o == '0 && !fault_n_o));

  // R7
  uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> on_o == '0);

endmodule

// File: tb/ocp_guard_bench.sv
module ocp_guard_bench;

  localparam int NCH = 4;
  localparam int DEG = 5;
  localparam int RET = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] lim, req;
  logic           ot, uv, clr;
  logic [NCH-1:0] on_w;
  logic           fn_w;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ocp_guard #(.NCH(NCH), .DEG_CYC(DEG), .RETRY_CYC(RET)) u_ocp_guard (
    .clk(clk), .rst_n(rst_n), .lim_i(lim), .ot_i(ot), .uv_i(uv),
    .clr_i(clr), .req_i(req), .on_o(on_w), .fault_n_o(fn_w)
  );

  // {req, ot, uv, expected on, expected fault_n}
  typedef struct packed {
    logic [3:0] req;
    logic       ot;
    logic       uv;
    logic [3:0] on;
    logic       fn;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'hF, 1'b0, 1'b0, 4'hF, 1'b1},
    '{4'h5, 1'b0, 1'b0, 4'h5, 1'b1},
    '{4'hA, 1'b0, 1'b0, 4'hA, 1'b1},
    '{4'hF, 1'b1, 1'b0, 4'h0, 1'b0},
    '{4'h3, 1'b1, 1'b0, 4'h0, 1'b0},
    '{4'hF, 1'b0, 1'b1, 4'h0, 1'b1},
    '{4'hC, 1'b1, 1'b1, 4'h0, 1'b0},
    '{4'h0, 1'b0, 1'b0, 4'h0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [3:0] e_on, input logic e_fn);
    n_chk++;
    if (on_w !== e_on || fn_w !== e_fn) begin
      n_fail++;
      $display("FAIL %s: on=%h fault_n=%b, expected on=%h fault_n=%b",
               rq, on_w, fn_w, e_on, e_fn);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: on=%h fault_n=%b, expected run to end", on_w, fn_w);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lim = '0; req = '0; ot = 1'b0; uv = 1'b0; clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R8 reset", 4'h0, 1'b1);

    // R8 R6 R7 static gating table
    for (int i = 0; i < 8; i++) begin
      req = VECS[i].req; ot = VECS[i].ot; uv = VECS[i].uv;
      step(1);
      chk("R8 table", VECS[i].on, VECS[i].fn);
    end
    req = 4'hF; ot = 1'b0; uv = 1'b0;
    step(1);

    // R2 short pulse and restart
    lim[0] = 1'b1; step(DEG - 1);
    chk("R2 short", 4'hF, 1'b1);
    lim[0] = 1'b0; step(1);
    lim[0] = 1'b1; step(DEG - 1);
    chk("R2 restart", 4'hF, 1'b1);
    // R1 exact window
    step(1);
    chk("R1 trip", 4'hE, 1'b0);
    // R4 holds RETRY edges, limit ignored
    step(RET - 1);
    chk("R4 hold", 4'hE, 1'b0);
    step(1);
    chk("R4 expire", 4'hF, 1'b1);
    // R4 count restarts after trip
    step(DEG - 1);
    chk("R4 recount", 4'hF, 1'b1);
    step(1);
    chk("R3 retrip", 4'hE, 1'b0);
    // R5 clear
    clr = 1'b1; step(1); clr = 1'b0;
    chk("R5 clear", 4'hF, 1'b1);
    step(DEG - 1);
    chk("R5 count dropped", 4'hF, 1'b1);
    lim[0] = 1'b0; step(1);

    // R7 undervoltage
    lim[2] = 1'b1; step(DEG);
    chk("R3 other chan", 4'hB, 1'b0);
    lim[2] = 1'b0;
    uv = 1'b1; #1;
    chk("R7 immediate off", 4'h0, 1'b0);
    step(1);
    chk("R7 trip cleared", 4'h0, 1'b1);
    uv = 1'b0; #1;
    chk("R7 resume", 4'hF, 1'b1);
    lim[1] = 1'b1; step(DEG - 1);
    uv = 1'b1; step(1); uv = 1'b0;
    step(DEG - 1);
    chk("R7 count dropped", 4'hF, 1'b1);
    lim[1] = 1'b0; step(1);

    // R6 over-temperature
    ot = 1'b1; #1;
    chk("R6 hot", 4'h0, 1'b0);
    step(3);
    chk("R6 hot held", 4'h0, 1'b0);
    ot = 1'b0; #1;
    chk("R6 resume", 4'hF, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule